// File: doc/BRIEF.md
# Daisy-Chained Peripheral Interrupt Controller

This block sits inside a peripheral that shares an 8-bit bus with a processor. The bus has separate strobes for I/O requests and for the first machine cycle of an instruction. The block gathers request pulses from several internal sources, such as parallel ports and timer channels. Each source has three flags: pending, enable and in-service. The block joins a serial priority chain with its neighbours through a chain-enable input and a chain-enable output. While any enabled source is pending or any source is in service, the block holds its chain output low so that every device further down the chain stays quiet.

Bus strobes are sampled on the block clock. The block classifies each sample as one of five kinds: register read, register write, interrupt acknowledge, opcode fetch or idle. Each classified cycle takes effect once, on its first clock. On an acknowledge the block drives an 8-bit vector. The vector is made of a programmable base with the index of the winning source inserted, and that source moves from pending to in-service. End of service is not signalled by a register write. Instead the block watches opcode fetches for the two-byte return-from-interrupt pair and then releases its highest-priority in-service source.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset (rst_n low for at least three clocks) the enable mask, the pending flags and the in-service flags are all zero, chain_out equals chain_in, and d_oe is low.
- R2: chain_out is high only when chain_in is high, no source is in service, and no source is both pending and enabled.
- R3: A write cycle (iorq_n=0, cs_n=0, rd_n=1, m1_n=1) stores d_in in the vector base at address 0 and d_in[NSRC-1:0] in the enable mask at address 1. Writes to any other address change nothing.
- R4: A read cycle (iorq_n=0, cs_n=0, rd_n=0, m1_n=1) raises d_oe and drives d_out as follows: address 0 gives the vector base, 1 the enable mask, 2 the pending flags, 3 the in-service flags, and any other address gives 0x00. Flag bit i belongs to source i.
- R5: A src_req bit seen high on a clock sets that source's pending flag, which then stays set until the source is acknowledged. A pending source whose enable bit is 0 neither blocks the chain nor wins an acknowledge.
- R6: An acknowledge cycle (iorq_n=0, m1_n=0) with chain_in high and at least one enabled pending source behaves as follows:
  - d_oe is raised for the whole cycle.
  - d_out is {base[7:4], idx[2:0], 1'b0}, where idx is the lowest-numbered enabled pending source (source 0 has the highest priority).
  - That source's pending flag is cleared and its in-service flag is set.
- R7: An acknowledge cycle with chain_in low, or with no enabled pending source, leaves d_oe low and changes no flag.
- R8: An opcode fetch is a cycle with m1_n=0, rd_n=0 and iorq_n=1, and its opcode byte is taken from d_in. A fetch of 0x4D that directly follows a fetch of 0xED, with no other fetch between them, clears the lowest-numbered set in-service flag. This happens only if chain_in is high during the 0x4D fetch. A broken pair clears nothing, and neither does a pair completed while chain_in is low.
- R9: d_oe is low on every cycle that is neither a decoded read nor a granted acknowledge.
- R10: A bus cycle whose strobes are held for several clocks acts only once. For example, a long acknowledge moves exactly one source to in-service and keeps driving the same vector throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | First machine cycle strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 4 | Register address |
| d_in | input | 8 | Data bus as driven by the processor (write data, opcodes) |
| d_out | output | 8 | Data returned to the processor |
| d_oe | output | 1 | Enable for the data bus driver |
| src_req | input | NSRC | Request pulses from the internal sources |
| chain_in | input | 1 | Chain enable from the higher-priority neighbour |
| chain_out | output | 1 | Chain enable to the lower-priority neighbour |

## Verification
Wrong pending, enable or in-service state surfaces in three places:
- chain_out, in the same cycle that the state goes wrong.
- The vector driven on the next acknowledge, because the winning index and the base nibble are both visible there.
- The flag registers, which can be read back directly.

A missed or spurious return-from-interrupt shows up as chain_out staying low, or rising early, after the 0x4D fetch. The sweep covers every combination of enable mask and request pattern. After each combination the bench drains the block through acknowledges and return sequences, so a stale flag is caught before the next pattern begins.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int IDX_W = 3;
  localparam logic [7:0] OP_PREFIX = 8'hED;
  localparam logic [7:0] OP_RETURN = 8'h4D;
  localparam logic [3:0] A_BASE = 4'd0;
  localparam logic [3:0] A_MASK = 4'd1;
  localparam logic [3:0] A_PEND = 4'd2;
  localparam logic [3:0] A_SERV = 4'd3;

  typedef enum logic [2:0] {
    BK_IDLE  = 3'd0,
    BK_READ  = 3'd1,
    BK_WRITE = 3'd2,
    BK_ACK   = 3'd3,
    BK_FETCH = 3'd4
  } bus_kind_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_chain_pkg::*;
(
  input  logic      clk,
  input  logic      rst_s_n,
  input  logic      iorq_n,
  input  logic      m1_n,
  input  logic      rd_n,
  input  logic      cs_n,
  output bus_kind_e kind,
  output logic      first
);
  bus_kind_e prev_q;

  always_comb begin
    kind = BK_IDLE;
    if (!iorq_n && !m1_n)                  kind = BK_ACK;
    else if (iorq_n && !m1_n && !rd_n)     kind = BK_FETCH;
    else if (!iorq_n && !cs_n && !rd_n)    kind = BK_READ;
    else if (!iorq_n && !cs_n && rd_n)     kind = BK_WRITE;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) prev_q <= BK_IDLE;
    else          prev_q <= kind;
  end

  assign first = (kind != BK_IDLE) && (kind != prev_q);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [2:0]   idx,
  output logic [N-1:0] onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx    = i[2:0];
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iorq_n,
  input  logic            m1_n,
  input  logic            rd_n,
  input  logic            cs_n,
  input  logic [3:0]      addr,
  input  logic [7:0]      d_in,
  output logic [7:0]      d_out,
  output logic            d_oe,
  input  logic [NSRC-1:0] src_req,
  input  logic            chain_in,
  output logic            chain_out
);
  localparam int PAD = 8 - NSRC;

  logic            rst_s_n;
  bus_kind_e       kind;
  logic            first;

  logic [7:0]      base_q, base_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] pend_q, pend_d;
  logic [NSRC-1:0] serv_q, serv_d;
  logic            live_q, live_d;
  logic [2:0]      hold_idx_q, hold_idx_d;
  logic            pfx_q, pfx_d;

  logic            win_any, serv_any;
  logic [2:0]      win_idx, serv_idx;
  logic [NSRC-1:0] win_oh, serv_oh;
  logic            grant, ack_drive;
  logic [2:0]      vec_idx;
  logic [7:0]      reg_val;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  irq_bus_decode u_dec (
    .clk(clk), .rst_s_n(rst_s_n), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .cs_n(cs_n), .kind(kind), .first(first)
  );

  irq_prio_pick #(.N(NSRC)) u_win (
    .req(pend_q & mask_q), .any(win_any), .idx(win_idx), .onehot(win_oh)
  );

  irq_prio_pick #(.N(NSRC)) u_serv (
    .req(serv_q), .any(serv_any), .idx(serv_idx), .onehot(serv_oh)
  );

  assign grant     = chain_in && win_any;
  assign chain_out = chain_in && !serv_any && !win_any;
  assign ack_drive = (kind == BK_ACK) && chain_in && (first ? grant : live_q);
  assign vec_idx   = first ? win_idx : hold_idx_q;

  always_comb begin
    base_d     = base_q;
    mask_d     = mask_q;
    pend_d     = pend_q | src_req;
    serv_d     = serv_q;
    live_d     = (kind == BK_ACK) ? live_q : 1'b0;
    hold_idx_d = hold_idx_q;
    pfx_d      = pfx_q;
    if (first) begin
      unique case (kind)
        BK_WRITE: begin
          if (addr == A_BASE) base_d = d_in;
          if (addr == A_MASK) mask_d = d_in[NSRC-1:0];
        end
        BK_ACK: begin
          if (grant) begin
            serv_d     = serv_q | win_oh;
            pend_d     = (pend_q | src_req) & ~win_oh;
            live_d     = 1'b1;
            hold_idx_d = win_idx;
          end
        end
        BK_FETCH: begin
          pfx_d = (d_in == OP_PREFIX);
          if (pfx_q && (d_in == OP_RETURN) && chain_in)
            serv_d = serv_q & ~serv_oh;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      base_q     <= '0;
      mask_q     <= '0;
      pend_q     <= '0;
      serv_q     <= '0;
      live_q     <= 1'b0;
      hold_idx_q <= '0;
      pfx_q      <= 1'b0;
    end else begin
      base_q     <= base_d;
      mask_q     <= mask_d;
      pend_q     <= pend_d;
      serv_q     <= serv_d;
      live_q     <= live_d;
      hold_idx_q <= hold_idx_d;
      pfx_q      <= pfx_d;
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      always_comb begin
        unique case (addr)
          A_BASE:  reg_val = base_q;
          A_MASK:  reg_val = {{PAD{1'b0}}, mask_q};
          A_PEND:  reg_val = {{PAD{1'b0}}, pend_q};
          A_SERV:  reg_val = {{PAD{1'b0}}, serv_q};
          default: reg_val = 8'h00;
        endcase
      end
    end else begin : g_full
      always_comb begin
        unique case (addr)
          A_BASE:  reg_val = base_q;
          A_MASK:  reg_val = mask_q;
          A_PEND:  reg_val = pend_q;
          A_SERV:  reg_val = serv_q;
          default: reg_val = 8'h00;
        endcase
      end
    end
  endgenerate

  always_comb begin
    d_out = 8'h00;
    d_oe  = 1'b0;
    if (kind == BK_READ) begin
      d_out = reg_val;
      d_oe  = 1'b1;
    end else if (ack_drive) begin
      d_out = {base_q[7:4], vec_idx, 1'b0};
      d_oe  = 1'b1;
    end
  end
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iorq_n,
  input logic            m1_n,
  input logic            rd_n,
  input logic            cs_n,
  input logic [7:0]      d_out,
  input logic            d_oe,
  input logic            chain_in,
  input logic            chain_out,
  input logic [NSRC-1:0] serv_q
);
  // R2
  chain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out |-> chain_in);

  // R2
  chain_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|serv_q) |-> !chain_out);

  // R9
  oe_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (!iorq_n && (!m1_n || (!cs_n && !rd_n))));

  // R6
  ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && !m1_n) |-> (d_out[0] == 1'b0 && chain_in));

  // R6
  ack_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && !m1_n && !iorq_n) |=> (|serv_q));

  // R7
  no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_in && !iorq_n && !m1_n) |-> !d_oe);
endmodule

bind irq_chain_ctrl irq_chain_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n),
  .cs_n(cs_n), .d_out(d_out), .d_oe(d_oe), .chain_in(chain_in),
  .chain_out(chain_out), .serv_q(serv_q)
);

// File: tb/irq_chain_ctrl_bench.sv
module irq_chain_ctrl_bench;
  localparam int NSRC = 4;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            iorq_n, m1_n, rd_n, cs_n;
  logic [3:0]      addr;
  logic [7:0]      d_in;
  logic [7:0]      d_out;
  logic            d_oe;
  logic [NSRC-1:0] src_req;
  logic            chain_in;
  logic            chain_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0]      m_base;
  logic [NSRC-1:0] m_mask, m_pend, m_serv;

  irq_chain_ctrl #(.NSRC(NSRC)) u_irq_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n),
    .cs_n(cs_n), .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .src_req(src_req), .chain_in(chain_in), .chain_out(chain_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NSRC-1:0] v);
    for (int i = NSRC - 1; i >= 0; i--) if (v[i]) lowest = i;
    if (v == '0) lowest = -1;
  endfunction

  function automatic logic [7:0] vec_of(input int idx);
    return {m_base[7:4], 4'b0000} | 8'(idx << 1);
  endfunction

  task automatic drive(input logic io, input logic m1, input logic rd, input logic cs,
                       input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    iorq_n = io; m1_n = m1; rd_n = rd; cs_n = cs; addr = a; d_in = d;
  endtask

  task automatic idle();
    drive(1, 1, 1, 1, 4'd0, 8'h00);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    drive(0, 1, 1, 0, a, d);
    idle();
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    drive(0, 1, 0, 0, a, 8'h00);
    #1;
    chk({tag, " oe"}, {7'd0, d_oe}, 8'd1);
    chk(tag, d_out, exp);
    idle();
  endtask

  task automatic pulse(input logic [NSRC-1:0] p);
    @(negedge clk); src_req = p;
    @(negedge clk); src_req = '0;
  endtask

  task automatic ack_chk(input string tag, input int nclk);
    int w;
    logic ok;
    w  = lowest(m_pend & m_mask);
    ok = chain_in && (w >= 0);
    drive(0, 0, 1, 1, 4'd0, 8'h00);
    for (int k = 0; k < nclk; k++) begin
      #1;
      chk({tag, " oe"}, {7'd0, d_oe}, {7'd0, ok});
      if (ok) chk({tag, " vec"}, d_out, vec_of(w));
      if (k < nclk - 1) @(negedge clk);
    end
    if (ok) begin
      m_serv[w] = 1'b1;
      m_pend[w] = 1'b0;
    end
    idle();
  endtask

  task automatic fetch(input logic [7:0] op);
    drive(1, 0, 0, 1, 4'd0, op);
    idle();
  endtask

  task automatic reti();
    int s;
    fetch(8'hED);
    fetch(8'h4D);
    s = lowest(m_serv);
    if (chain_in && s >= 0) m_serv[s] = 1'b0;
  endtask

  task automatic chain_chk(input string tag);
    logic exp;
    #1;
    exp = chain_in && (m_serv == '0) && ((m_pend & m_mask) == '0);
    chk(tag, {7'd0, chain_out}, {7'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; iorq_n = 1; m1_n = 1; rd_n = 1; cs_n = 1;
    addr = '0; d_in = '0; src_req = '0; chain_in = 1'b1;
    m_base = '0; m_mask = '0; m_pend = '0; m_serv = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    #1;
    chk("R1 oe", {7'd0, d_oe}, 8'd0);
    chk("R1 chain", {7'd0, chain_out}, 8'd1);
    rd_chk("R1 mask", 4'd1, 8'h00);
    rd_chk("R1 pend", 4'd2, 8'h00);
    rd_chk("R1 serv", 4'd3, 8'h00);

    // R3 / R4 registers and unused addresses
    wr(4'd0, 8'hA5); m_base = 8'hA5;
    rd_chk("R3 base", 4'd0, 8'hA5);
    wr(4'd7, 8'h3C);
    rd_chk("R3 ignored base", 4'd0, 8'hA5);
    rd_chk("R3 ignored mask", 4'd1, 8'h00);
    rd_chk("R4 unused addr", 4'd9, 8'h00);
    #1; chk("R9 idle oe", {7'd0, d_oe}, 8'd0);

    // R5 disabled pending does not block
    pulse(4'b0100); m_pend = 4'b0100;
    chain_chk("R5 disabled pending chain");
    rd_chk("R5 pend", 4'd2, 8'h04);
    ack_chk("R7 no enabled source", 1);

    // R7 chain_in low blocks the acknowledge
    wr(4'd1, 8'h0F); m_mask = 4'hF;
    chain_in = 1'b0;
    ack_chk("R7 chain low", 1);
    rd_chk("R7 serv unchanged", 4'd3, 8'h00);
    chain_in = 1'b1;

    // R10 long acknowledge with two candidates moves only one
    pulse(4'b0010); m_pend = m_pend | 4'b0010;
    ack_chk("R10 long ack", 3);
    rd_chk("R10 serv one", 4'd3, {4'd0, m_serv});
    chain_chk("R2 busy chain");

    // R8 broken pair and chain-low pair do not release
    fetch(8'hED); fetch(8'h00); fetch(8'h4D);
    rd_chk("R8 broken pair", 4'd3, {4'd0, m_serv});
    chain_in = 1'b0;
    reti();
    rd_chk("R8 chain low pair", 4'd3, {4'd0, m_serv});
    chain_in = 1'b1;
    reti();
    rd_chk("R8 release", 4'd3, {4'd0, m_serv});
    while (m_pend != '0) ack_chk("R6 drain", 1);
    while (m_serv != '0) reti();
    chain_chk("R8 all released chain");

    // R2 R5 R6 sweep of masks and request patterns
    for (int b = 0; b < 2; b++) begin
      wr(4'd0, b ? 8'h3C : 8'hF0); m_base = b ? 8'h3C : 8'hF0;
      for (int m = 0; m < 16; m++) begin
        for (int p = 0; p < 16; p++) begin
          pulse(p[3:0]); m_pend = m_pend | p[3:0];
          wr(4'd1, 8'(m)); m_mask = m[3:0];
          rd_chk("R5 sweep pend", 4'd2, {4'd0, m_pend});
          rd_chk("R3 sweep mask", 4'd1, {4'd0, m_mask});
          chain_chk("R2 sweep chain");
          ack_chk("R6 sweep ack", 1);
          chain_chk("R2 after ack");
          wr(4'd1, 8'h0F); m_mask = 4'hF;
          while (m_pend != '0) ack_chk("R6 sweep drain", 1);
          while (m_serv != '0) reti();
          rd_chk("R8 sweep serv", 4'd3, 8'h00);
          chain_chk("R8 sweep chain");
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule